// File: doc/BRIEF.md
# Three-Wire Configuration Receiver with Control Register Bank

This block takes configuration frames from a three-wire serial bus (an active-high frame enable, a serial clock and a data line) and stores them in a set of control registers. The three bus inputs are treated as asynchronous. They pass through synchronizers into the system clock domain. Each rising edge of the serial clock seen while enable is high shifts one data bit in and advances a bit counter.

When enable drops, the block checks the frame. The number of bits received (16 or 24) and a two-bit address field together choose one target register, so the same address code selects different registers in short and long frames. The chosen register is then loaded in a single system clock cycle. Frames of any other length, and address codes with no register behind them, change nothing.

The outputs are plain parallel control words: a crystal trim capacitor code, gain and offset codes for two alignment converters, a three-bit level for a third converter, a reference divider and a main divider, a pump current select, an oscillator buffer disable, a band select and four switch-off bits. There is no streaming interface. The bus has no back-pressure, and every output is a level that holds until a valid frame replaces it.

Top module: `tw_cfg_regs`

## Requirements
- R1: While reset is high, every output reads zero except `buf_off`, which reads 1, and all four `sw_off` bits, which read 1.
- R2: The k-th bit shifted in is frame bit k. Bytes go out first byte first, each byte least significant bit first, so frame bits [1:0] form the address. A 16-bit frame with address 0 loads `dac1_gain` from frame bits [9:2] and `dac1_ofs` from bits [15:10].
- R3: A 16-bit frame with address 1 loads `dac2_gain` from bits [9:2] and `dac2_ofs` from bits [15:10].
- R4: A 16-bit frame with address 2 loads `xtal_cap` from bits [9:2].
- R5: A 24-bit frame with address 0 loads `ref_div` from bits [17:2], `dac3_lvl` from bits [20:18], `buf_off` from bit 21 (0 = buffer on) and `cp_sel` from bits [23:22].
- R6: A 24-bit frame with address 1 loads `main_div` from bits [17:2], `sw_off[3:0]` from bits [21:18] (1 = switch off) and `band_am` from bit 22 (1 = AM, 0 = FM).
- R7: A frame whose bit count is neither 16 nor 24 when enable falls leaves every output unchanged. This includes frames longer than 24 bits. The bit count restarts at zero for each new frame.
- R8: A 16-bit frame with address 3, and a 24-bit frame with address 2 or 3, leave every output unchanged.
- R9: Outputs change only in the cycle after the synchronized enable is seen to fall. While enable is still high at the end of a complete frame, the outputs keep their old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Frame enable, high while a frame is sent |
| bus_clk | input | 1 | Serial bit clock; data is taken on its rising edge |
| bus_dat | input | 1 | Serial data |
| xtal_cap | output | 8 | Crystal trim capacitor code, 0.5 pF per step |
| dac1_gain | output | 8 | Converter 1 gain code |
| dac1_ofs | output | 6 | Converter 1 offset code |
| dac2_gain | output | 8 | Converter 2 gain code |
| dac2_ofs | output | 6 | Converter 2 offset code |
| dac3_lvl | output | 3 | Converter 3 level code |
| ref_div | output | 16 | Reference divider value |
| main_div | output | 16 | Main divider value |
| cp_sel | output | 2 | Pump current select |
| buf_off | output | 1 | Oscillator buffer disable (1 = off) |
| band_am | output | 1 | Band select (1 = AM, 0 = FM) |
| sw_off | output | 4 | Switch output disables (1 = off) |

## Verification
The bench aims at the decode corners. It sends the same address code in a 16-bit frame and in a 24-bit frame. A decoder that ignored the length would load the converter word where the reference divider belongs, or the reverse. It sends frames of 8, 20 and 25 bits, and a long frame sent right after a bad one. A counter that wrapped, or failed to restart, would accept a wrong length or refuse a good one. It also sends the unused address codes, and inspects the outputs while enable is still high after a full frame. An early commit would show up there, as would a bit-order or byte-order swap, because the gain and divider patterns are asymmetric.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;
  localparam int ADDR_W = 2;
  localparam int GAIN_W = 8;
  localparam int OFS_W  = 6;
  localparam int CAP_W  = 8;
  localparam int DIV_W  = 16;
  localparam int D3_W   = 3;
  localparam int CP_W   = 2;
  localparam int SW_N   = 4;

  localparam int SHORT_LEN = ADDR_W + GAIN_W + OFS_W;          // 16
  localparam int LONG_LEN  = ADDR_W + DIV_W + D3_W + 1 + CP_W; // 24
  localparam int CNT_W     = $clog2(LONG_LEN + 1) + 1;

  // field positions inside the normalized frame word
  localparam int GAIN_LO = ADDR_W;
  localparam int OFS_LO  = ADDR_W + GAIN_W;
  localparam int DIV_LO  = ADDR_W;
  localparam int D3_LO   = ADDR_W + DIV_W;
  localparam int BOFF_B  = D3_LO + D3_W;
  localparam int CP_LO   = BOFF_B + 1;
  localparam int SW_LO   = ADDR_W + DIV_W;
  localparam int BAND_B  = SW_LO + SW_N;

  typedef enum logic [ADDR_W-1:0] {
    S_DAC1 = 2'd0, S_DAC2 = 2'd1, S_CAP = 2'd2, S_NONE = 2'd3
  } short_addr_e;

  typedef enum logic [ADDR_W-1:0] {
    L_REF = 2'd0, L_MAIN = 2'd1, L_RSV2 = 2'd2, L_RSV3 = 2'd3
  } long_addr_e;

  typedef struct packed {
    logic dac1;
    logic dac2;
    logic cap;
    logic refd;
    logic maind;
  } wr_sel_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[i] <= '0;
      else     st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/tw_shift.sv
module tw_shift
  import tw_cfg_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                shift,
  input  logic                bit_in,
  output logic [LONG_LEN-1:0] sr,
  output logic [CNT_W-1:0]    cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (shift) begin
      sr <= {bit_in, sr[LONG_LEN-1:1]};
      if (cnt != '1) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tw_decode.sv
module tw_decode
  import tw_cfg_pkg::*;
(
  input  logic                frame_end,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [LONG_LEN-1:0] sr,
  output wr_sel_t             sel,
  output logic [LONG_LEN-1:0] fw
);
  logic is_short, is_long;

  always_comb begin
    is_short = (cnt == CNT_W'(SHORT_LEN));
    is_long  = (cnt == CNT_W'(LONG_LEN));
    fw = is_short ? {{(LONG_LEN-SHORT_LEN){1'b0}}, sr[LONG_LEN-1 -: SHORT_LEN]} : sr;
    sel = '0;
    if (frame_end && is_short) begin
      case (short_addr_e'(fw[ADDR_W-1:0]))
        S_DAC1:  sel.dac1 = 1'b1;
        S_DAC2:  sel.dac2 = 1'b1;
        S_CAP:   sel.cap  = 1'b1;
        default: ;
      endcase
    end else if (frame_end && is_long) begin
      case (long_addr_e'(fw[ADDR_W-1:0]))
        L_REF:   sel.refd  = 1'b1;
        L_MAIN:  sel.maind = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tw_cfg_regs.sv
module tw_cfg_regs
  import tw_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_clk,
  input  logic              bus_dat,
  output logic [CAP_W-1:0]  xtal_cap,
  output logic [GAIN_W-1:0] dac1_gain,
  output logic [OFS_W-1:0]  dac1_ofs,
  output logic [GAIN_W-1:0] dac2_gain,
  output logic [OFS_W-1:0]  dac2_ofs,
  output logic [D3_W-1:0]   dac3_lvl,
  output logic [DIV_W-1:0]  ref_div,
  output logic [DIV_W-1:0]  main_div,
  output logic [CP_W-1:0]   cp_sel,
  output logic              buf_off,
  output logic              band_am,
  output logic [SW_N-1:0]   sw_off
);
  logic [2:0]          bus_s;
  logic                en_s, sclk_s, dat_s;
  logic                en_d, sclk_d;
  logic                frame_end, shift;
  logic [LONG_LEN-1:0] shreg, fw;
  logic [CNT_W-1:0]    bit_cnt;
  wr_sel_t             sel;

  tw_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk(clk), .rst(rst), .d({bus_en, bus_clk, bus_dat}), .q(bus_s)
  );
  assign {en_s, sclk_s, dat_s} = bus_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d   <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      en_d   <= en_s;
      sclk_d <= sclk_s;
    end
  end

  assign shift     = en_s & sclk_s & ~sclk_d;
  assign frame_end = en_d & ~en_s;

  tw_shift u_shift (
    .clk(clk), .rst(rst), .clear(~en_s), .shift(shift), .bit_in(dat_s),
    .sr(shreg), .cnt(bit_cnt)
  );

  tw_decode u_dec (
    .frame_end(frame_end), .cnt(bit_cnt), .sr(shreg), .sel(sel), .fw(fw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xtal_cap  <= '0;
      dac1_gain <= '0;
      dac1_ofs  <= '0;
      dac2_gain <= '0;
      dac2_ofs  <= '0;
      dac3_lvl  <= '0;
      ref_div   <= '0;
      main_div  <= '0;
      cp_sel    <= '0;
      buf_off   <= 1'b1;
      band_am   <= 1'b0;
      sw_off    <= '1;
    end else begin
      if (sel.dac1) begin
        dac1_gain <= fw[GAIN_LO +: GAIN_W];
        dac1_ofs  <= fw[OFS_LO +: OFS_W];
      end
      if (sel.dac2) begin
        dac2_gain <= fw[GAIN_LO +: GAIN_W];
        dac2_ofs  <= fw[OFS_LO +: OFS_W];
      end
      if (sel.cap) xtal_cap <= fw[GAIN_LO +: CAP_W];
      if (sel.refd) begin
        ref_div  <= fw[DIV_LO +: DIV_W];
        dac3_lvl <= fw[D3_LO +: D3_W];
        buf_off  <= fw[BOFF_B];
        cp_sel   <= fw[CP_LO +: CP_W];
      end
      if (sel.maind) begin
        main_div <= fw[DIV_LO +: DIV_W];
        sw_off   <= fw[SW_LO +: SW_N];
        band_am  <= fw[BAND_B];
      end
    end
  end
endmodule

// File: rtl/tw_cfg_regs_chk.sv
module tw_cfg_regs_chk
  import tw_cfg_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                frame_end,
  input logic [CNT_W-1:0]    bit_cnt,
  input logic [LONG_LEN-1:0] shreg,
  input logic [CAP_W-1:0]    xtal_cap,
  input logic [GAIN_W-1:0]   dac1_gain,
  input logic [OFS_W-1:0]    dac1_ofs,
  input logic [GAIN_W-1:0]   dac2_gain,
  input logic [OFS_W-1:0]    dac2_ofs,
  input logic [D3_W-1:0]     dac3_lvl,
  input logic [DIV_W-1:0]    ref_div,
  input logic [DIV_W-1:0]    main_div,
  input logic [CP_W-1:0]     cp_sel,
  input logic                buf_off,
  input logic                band_am,
  input logic [SW_N-1:0]     sw_off
);
  localparam int SOFF = LONG_LEN - SHORT_LEN;

  logic [78:0] vec;
  logic        short_f, long_f, rst_seen;

  assign vec = {xtal_cap, dac1_gain, dac1_ofs, dac2_gain, dac2_ofs, dac3_lvl,
                ref_div, main_div, cp_sel, buf_off, band_am, sw_off};
  assign short_f = (bit_cnt == CNT_W'(SHORT_LEN));
  assign long_f  = (bit_cnt == CNT_W'(LONG_LEN));

  always_ff @(posedge clk) rst_seen <= rst;

  // R1: reset values
  always_ff @(posedge clk) begin
    if (rst_seen)
      p_reset_vals_r1: assert (buf_off && (&sw_off) && ref_div == '0 && main_div == '0
                               && dac1_gain == '0 && xtal_cap == '0 && !band_am);
  end

  p_dac1_load_r2: assert property (@(posedge clk) disable iff (rst)
    frame_end && short_f && shreg[SOFF +: ADDR_W] == 2'd0 |=>
      dac1_gain == $past(shreg[SOFF+GAIN_LO +: GAIN_W]) &&
      dac1_ofs  == $past(shreg[SOFF+OFS_LO +: OFS_W]));

  p_ref_load_r5: assert property (@(posedge clk) disable iff (rst)
    frame_end && long_f && shreg[ADDR_W-1:0] == 2'd0 |=>
      ref_div == $past(shreg[DIV_LO +: DIV_W]) && buf_off == $past(shreg[BOFF_B]));

  p_bad_len_r7: assert property (@(posedge clk) disable iff (rst)
    frame_end && !short_f && !long_f |=> $stable(vec));

  p_bad_addr_r8: assert property (@(posedge clk) disable iff (rst)
    frame_end && ((short_f && shreg[SOFF +: ADDR_W] == 2'd3) ||
                  (long_f && shreg[ADDR_W-1])) |=> $stable(vec));

  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(vec));
endmodule

bind tw_cfg_regs tw_cfg_regs_chk u_chk (
  .clk(clk), .rst(rst), .frame_end(frame_end), .bit_cnt(bit_cnt), .shreg(shreg),
  .xtal_cap(xtal_cap), .dac1_gain(dac1_gain), .dac1_ofs(dac1_ofs),
  .dac2_gain(dac2_gain), .dac2_ofs(dac2_ofs), .dac3_lvl(dac3_lvl),
  .ref_div(ref_div), .main_div(main_div), .cp_sel(cp_sel), .buf_off(buf_off),
  .band_am(band_am), .sw_off(sw_off)
);

// File: tb/tw_cfg_regs_bench.sv
module tw_cfg_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_clk = 1'b0, bus_dat = 1'b0;
  logic [7:0]  xtal_cap, dac1_gain, dac2_gain;
  logic [5:0]  dac1_ofs, dac2_ofs;
  logic [2:0]  dac3_lvl;
  logic [15:0] ref_div, main_div;
  logic [1:0]  cp_sel;
  logic        buf_off, band_am;
  logic [3:0]  sw_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  tw_cfg_regs u_tw_cfg_regs (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_clk(bus_clk), .bus_dat(bus_dat),
    .xtal_cap(xtal_cap), .dac1_gain(dac1_gain), .dac1_ofs(dac1_ofs),
    .dac2_gain(dac2_gain), .dac2_ofs(dac2_ofs), .dac3_lvl(dac3_lvl),
    .ref_div(ref_div), .main_div(main_div), .cp_sel(cp_sel), .buf_off(buf_off),
    .band_am(band_am), .sw_off(sw_off)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n);
    bus_en = 1'b1;
    wait_cyc(4);
    for (int k = 0; k < n; k++) begin
      bus_dat = bits[k];
      wait_cyc(4);
      bus_clk = 1'b1;
      wait_cyc(4);
      bus_clk = 1'b0;
    end
    wait_cyc(4);
  endtask

  task automatic end_frame;
    bus_en = 1'b0;
    wait_cyc(8);
  endtask

  task automatic send_frame(input logic [31:0] bits, input int n);
    send_bits(bits, n);
    end_frame();
  endtask

  function automatic logic [15:0] f_dac(input logic [1:0] a, input logic [7:0] g,
                                        input logic [5:0] o);
    return {o, g, a};
  endfunction

  task automatic t_reset;
    chk("R1", "xtal_cap", 32'(xtal_cap), 0);
    chk("R1", "dac1", 32'({dac1_gain, dac1_ofs}), 0);
    chk("R1", "dac2", 32'({dac2_gain, dac2_ofs}), 0);
    chk("R1", "dac3_lvl", 32'(dac3_lvl), 0);
    chk("R1", "dividers", {ref_div, main_div}, 0);
    chk("R1", "cp_sel", 32'(cp_sel), 0);
    chk("R1", "buf_off", 32'(buf_off), 1);
    chk("R1", "band_am", 32'(band_am), 0);
    chk("R1", "sw_off", 32'(sw_off), 32'hF);
  endtask

  task automatic t_dac1;
    send_bits(32'(f_dac(2'd0, 8'hA5, 6'h2C)), 16);
    chk("R9", "dac1_gain before enable drop", 32'(dac1_gain), 0);
    end_frame();
    chk("R2", "dac1_gain", 32'(dac1_gain), 32'hA5);
    chk("R2", "dac1_ofs", 32'(dac1_ofs), 32'h2C);
    chk("R2", "dac2 untouched", 32'({dac2_gain, dac2_ofs}), 0);
  endtask

  task automatic t_dac2;
    send_frame(32'(f_dac(2'd1, 8'h3C, 6'h15)), 16);
    chk("R3", "dac2_gain", 32'(dac2_gain), 32'h3C);
    chk("R3", "dac2_ofs", 32'(dac2_ofs), 32'h15);
    chk("R3", "dac1 kept", 32'(dac1_gain), 32'hA5);
  endtask

  task automatic t_cap;
    send_frame(32'({6'h3F, 8'h81, 2'd2}), 16);
    chk("R4", "xtal_cap", 32'(xtal_cap), 32'h81);
    chk("R4", "dac1 kept", 32'({dac1_gain, dac1_ofs}), 32'({8'hA5, 6'h2C}));
  endtask

  task automatic t_ref;
    send_frame(32'({2'd2, 1'b0, 3'd5, 16'hBEEF, 2'd0}), 24);
    chk("R5", "ref_div", 32'(ref_div), 32'hBEEF);
    chk("R5", "dac3_lvl", 32'(dac3_lvl), 5);
    chk("R5", "buf_off", 32'(buf_off), 0);
    chk("R5", "cp_sel", 32'(cp_sel), 2);
    chk("R5", "dac1 not hit by long addr 0", 32'(dac1_gain), 32'hA5);
  endtask

  task automatic t_main;
    send_frame(32'({1'b0, 1'b1, 4'b1010, 16'h1234, 2'd1}), 24);
    chk("R6", "main_div", 32'(main_div), 32'h1234);
    chk("R6", "sw_off", 32'(sw_off), 32'hA);
    chk("R6", "band_am", 32'(band_am), 1);
    chk("R6", "dac2 not hit by long addr 1", 32'(dac2_gain), 32'h3C);
  endtask

  task automatic t_bad_len;
    send_frame(32'h00F_FFFC, 20);
    chk("R7", "20-bit frame ref_div", 32'(ref_div), 32'hBEEF);
    chk("R7", "20-bit frame dac1", 32'(dac1_gain), 32'hA5);
    send_frame(32'h0000_00FC, 8);
    chk("R7", "8-bit frame dac1", 32'(dac1_gain), 32'hA5);
    send_frame(32'h01FF_FFFC, 25);
    chk("R7", "25-bit frame ref_div", 32'(ref_div), 32'hBEEF);
    chk("R7", "25-bit frame cp_sel", 32'(cp_sel), 2);
    send_frame(32'({2'd1, 1'b1, 3'd2, 16'h0F0F, 2'd0}), 24);
    chk("R7", "count restarts, ref_div", 32'(ref_div), 32'h0F0F);
    chk("R7", "count restarts, buf_off", 32'(buf_off), 1);
  endtask

  task automatic t_bad_addr;
    send_frame(32'(f_dac(2'd3, 8'h11, 6'h22)), 16);
    chk("R8", "short addr 3 dac1", 32'(dac1_gain), 32'hA5);
    chk("R8", "short addr 3 dac2", 32'(dac2_gain), 32'h3C);
    chk("R8", "short addr 3 cap", 32'(xtal_cap), 32'h81);
    send_frame(32'({8'hFF, 16'h5555, 2'd2}), 26);
    send_frame(32'({8'hFF, 14'h1555, 2'd2}), 24);
    chk("R8", "long addr 2 ref_div", 32'(ref_div), 32'h0F0F);
    chk("R8", "long addr 2 main_div", 32'(main_div), 32'h1234);
    send_frame(32'({8'h00, 14'h0AAA, 2'd3}), 24);
    chk("R8", "long addr 3 main_div", 32'(main_div), 32'h1234);
    chk("R8", "long addr 3 sw_off", 32'(sw_off), 32'hA);
  endtask

  initial begin
    wait_cyc(4);
    t_reset();
    rst = 1'b0;
    wait_cyc(2);
    t_dac1();
    t_dac2();
    t_cap();
    t_ref();
    t_main();
    t_bad_len();
    t_bad_addr();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule